// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM read or write burst. A column command loads a starting column together with the burst length code, the ordering (sequential or interleaved) and the write-burst setting. From the next clock on the block presents one column per enabled cycle, with a valid flag and a flag marking the final beat.

Sequential bursts count upward and wrap inside the aligned block of the burst length. Interleaved bursts XOR the start column's low bits with the beat index. Column bits above the burst block stay fixed. A full-page burst walks the whole row and keeps cycling until a stop or a new command ends it. A new command restarts the generator on any cycle. A low clock enable freezes the generator. The column width is a parameter, normally 8 or 9 bits.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after it is released, valid_o and last_o are low until the first accepted column command.
- R2: Length codes 000, 001, 010 and 011 give 1, 2, 4 and 8 beats. The first beat appears the cycle after the command. last_o is high on the final beat only. valid_o drops on the next enabled cycle after the final beat.
- R3: In sequential order (interleave_i=0) the column counts upward and wraps inside the aligned block of the burst length. For example, length 4 starting at 2 gives 2, 3, 0, 1.
- R4: In interleaved order (interleave_i=1) beat k presents the start column's low bits XOR k. For example, length 8 starting at 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R5: Column bits above the burst block equal those of the start column for the whole burst.
- R6: Code 111 in sequential order is a full-page burst. It steps through all 2^COL_W columns from the start column, wraps around the row and repeats, and never asserts last_o.
- R7: Codes 100, 101 and 110, and code 111 with interleave_i=1, behave as length 1.
- R8: An accepted command (start_i high with cke_i high) loads the new column on any cycle and aborts the running burst. It takes priority over stop_i.
- R9: While cke_i is low, col_o, valid_o and last_o hold their values, and start_i and stop_i are ignored.
- R10: A write command (is_write_i=1) with single_write_i=1 is always length 1. single_write_i has no effect on reads.
- R11: stop_i with cke_i high and no command ends the running burst: valid_o is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes the generator |
| start_i | input | 1 | Column command: load col_i and start a burst |
| stop_i | input | 1 | Burst stop |
| is_write_i | input | 1 | Command is a write |
| col_i | input | COL_W | Start column |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| single_write_i | input | 1 | Writes use length 1 |
| col_o | output | COL_W | Current column |
| valid_o | output | 1 | A burst beat is presented |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
The assertions check several rules on every cycle. A low clock enable freezes all outputs. Upper column bits hold through a finite burst. The least significant column bit toggles on every step inside a burst. A last beat, a stop or an accepted command has its required effect on valid one cycle later. A full-page burst never raises last. The exact column order cannot be reached by these local checks: sequential wrap points, interleaved XOR patterns, the full-row walk with its wrap, reserved-code fallback and the single-write override are shown only by the bench, which compares every beat with a reference sequence. The bench covers both directed corner cases and random command, stop and enable traffic.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic [1:0] lg;    // log2 of finite length
    logic       full;  // full-page burst
    logic       ilv;   // interleaved order
  } burst_cfg_t;

  // low-bit block mask for a finite burst
  function automatic logic [2:0] blk_mask(input logic [1:0] lg);
    logic [2:0] m;
    m = 3'((4'd1 << lg) - 4'd1);
    return m;
  endfunction

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
(
  input  logic [2:0] len_code_i,
  input  logic       interleave_i,
  input  logic       is_write_i,
  input  logic       single_write_i,
  output burst_cfg_t cfg_o
);

  always_comb begin
    cfg_o      = '0;
    cfg_o.ilv  = interleave_i;
    if (!(is_write_i && single_write_i)) begin
      unique case (len_code_i)
        LEN_1:    cfg_o.lg = 2'd0;
        LEN_2:    cfg_o.lg = 2'd1;
        LEN_4:    cfg_o.lg = 2'd2;
        LEN_8:    cfg_o.lg = 2'd3;
        LEN_PAGE: cfg_o.full = !interleave_i;
        default:  cfg_o.lg = 2'd0;
      endcase
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] beat_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] beat_q;
  logic             act_q;
  logic [COL_W-1:0] end_beat;

  assign end_beat = COL_W'(blk_mask(cfg_i.lg));
  assign last_o   = act_q && !cfg_i.full && (beat_q == end_beat);
  assign valid_o  = act_q;
  assign beat_o   = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      act_q  <= 1'b0;
    end else if (cke_i) begin
      if (start_i) begin
        beat_q <= '0;
        act_q  <= 1'b1;
      end else if (act_q) begin
        if (stop_i || last_o) act_q <= 1'b0;
        else                  beat_q <= beat_q + 1'b1;  // full page wraps by width
      end
    end
  end

  a_r2_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && last_o && !start_i |=> !valid_o);
  a_r6_full_no_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && cfg_i.full |-> !last_o);
  a_r8_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && start_i |=> valid_o && (beat_o == '0));
  a_r11_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && stop_i && !start_i |=> !valid_o);

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] low;

  assign mask = cfg_i.full ? '1 : COL_W'(blk_mask(cfg_i.lg));
  assign low  = cfg_i.ilv ? (base_i ^ beat_i) : (base_i + beat_i);
  assign col_o = (base_i & ~mask) | (low & mask);

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cke_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             single_write_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  localparam int HI_LSB = 3;  // first bit above the largest finite block

  burst_cfg_t       cfg_d, cfg_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat;

  burst_len_decode u_dec (
    .len_code_i     (len_code_i),
    .interleave_i   (interleave_i),
    .is_write_i     (is_write_i),
    .single_write_i (single_write_i),
    .cfg_o          (cfg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cfg_q  <= '0;
    end else if (cke_i && start_i) begin
      base_q <= col_i;
      cfg_q  <= cfg_d;
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cke_i   (cke_i),
    .start_i (start_i),
    .stop_i  (stop_i),
    .cfg_i   (cfg_q),
    .beat_o  (beat),
    .valid_o (valid_o),
    .last_o  (last_o)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i (base_q),
    .beat_i (beat),
    .cfg_i  (cfg_q),
    .col_o  (col_o)
  );

  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> $stable(col_o) && $stable(valid_o) && $stable(last_o));
  a_r5_upper_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && valid_o && !start_i && !cfg_q.full |=> $stable(col_o[COL_W-1:HI_LSB]));
  a_r3_lsb_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_i && valid_o && !last_o && !start_i && !stop_i |=> col_o[0] != $past(col_o[0]));

endmodule

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb_top;

  localparam int COL_W   = 9;
  localparam int NCOL    = 1 << COL_W;
  localparam int CLK_PER = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cke = 1'b1, start = 1'b0, stop = 1'b0, wr = 1'b0;
  logic [COL_W-1:0] col = '0;
  logic [2:0]       code = '0;
  logic             ilv = 1'b0, sw = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  bit m_act = 0;
  int m_base = 0, m_beat = 0, m_len = 1;  // m_len 0 = full page
  bit m_ilv = 0;

  always #(CLK_PER/2) clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .start_i(start), .stop_i(stop),
    .is_write_i(wr), .col_i(col), .len_code_i(code), .interleave_i(ilv),
    .single_write_i(sw), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int dec_len(input logic [2:0] c, input bit i, input bit w, input bit s);
    if (w && s) return 1;
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return i ? 1 : 0;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int b, input int k, input int len, input bit i);
    if (len == 0) return (b + k) % NCOL;
    if (i) return b ^ k;
    return (b / len) * len + ((b % len) + k) % len;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input string req);
    @(posedge clk);
    if (cke) begin
      if (start) begin
        m_act = 1; m_base = int'(col); m_beat = 0;
        m_len = dec_len(code, ilv, wr, sw); m_ilv = ilv;
      end else if (m_act) begin
        if (stop || (m_len != 0 && m_beat == m_len - 1)) m_act = 0;
        else m_beat = (m_beat + 1) % (m_len == 0 ? NCOL : m_len);
      end
    end
    @(negedge clk);
    chk({req, " valid"}, int'(valid_o), int'(m_act));
    chk({req, " last"}, int'(last_o), int'(m_act && m_len != 0 && m_beat == m_len - 1));
    if (m_act) chk({req, " col"}, int'(col_o), exp_col(m_base, m_beat, m_len, m_ilv));
  endtask

  task automatic cmd(input int c, input logic [2:0] lc, input bit i, input bit w, input bit s);
    start = 1; col = COL_W'(c); code = lc; ilv = i; wr = w; sw = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(valid_o), 0);
    chk("R1 reset last", int'(last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc("R1");

    // R2 each length, R3 sequential wrap, R5 upper bits
    for (int lc = 0; lc < 4; lc++) begin
      cmd(9'h1A6, 3'(lc), 0, 0, 0); cyc("R2");
      start = 0;
      repeat (9) cyc("R2/R3/R5");
    end
    cmd(2, 3'b010, 0, 0, 0); cyc("R3"); start = 0;
    repeat (4) cyc("R3");
    // R4 interleaved
    cmd(9'h105, 3'b011, 1, 0, 0); cyc("R4"); start = 0;
    repeat (9) cyc("R4/R5");
    cmd(6, 3'b010, 1, 0, 0); cyc("R4"); start = 0;
    repeat (5) cyc("R4");
    // R7 reserved codes
    for (int lc = 4; lc < 8; lc++) begin
      cmd(77, 3'(lc), lc == 7, 0, 0); cyc("R7"); start = 0;
      repeat (2) cyc("R7");
    end
    // R10 single write vs read
    cmd(40, 3'b011, 0, 1, 1); cyc("R10"); start = 0;
    repeat (2) cyc("R10");
    cmd(40, 3'b011, 0, 0, 1); cyc("R10 read"); start = 0;
    repeat (8) cyc("R10 read");
    // R6 full page over the whole row and wrap
    cmd(NCOL - 3, 3'b111, 0, 0, 0); cyc("R6"); start = 0;
    repeat (NCOL + 5) cyc("R6");
    stop = 1; cyc("R11"); stop = 0;
    cyc("R11");
    // R8 restart mid burst, priority over stop
    cmd(16, 3'b011, 0, 0, 0); cyc("R8"); start = 0;
    repeat (3) cyc("R8");
    cmd(33, 3'b010, 1, 0, 0); stop = 1; cyc("R8 prio"); start = 0; stop = 0;
    repeat (4) cyc("R8");
    // R9 freeze: start and stop ignored
    cmd(50, 3'b011, 0, 0, 0); cyc("R9"); start = 0;
    cyc("R9");
    cke = 0; cmd(200, 3'b001, 1, 0, 0); stop = 1;
    repeat (3) cyc("R9");
    cke = 1; start = 0; stop = 0;
    repeat (8) cyc("R9");
    // R11 stop in finite burst
    cmd(8, 3'b011, 0, 0, 0); cyc("R11"); start = 0;
    cyc("R11"); stop = 1; cyc("R11"); stop = 0; cyc("R11");

    // random traffic
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      cke   = ($urandom % 100) < 85;
      start = ($urandom % 100) < 12;
      stop  = ($urandom % 100) < 4;
      col   = COL_W'($urandom);
      code  = (($urandom % 4) == 0) ? 3'($urandom) : 3'($urandom % 4);
      ilv   = 1'($urandom); wr = 1'($urandom); sw = (($urandom % 4) == 0);
      cyc("R2-random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule